// File: doc/BRIEF.md
# Frequency-Target Supply Voltage Loop

This block is the slow outer loop of a two-loop margin scheme. A fast inner loop trims the core clock to keep the timing margin fixed. This block sets the supply voltage that the inner loop works against. It receives a requested frequency code and the frequency code that the inner loop actually reached. On each evaluation it moves the voltage code one step up, one step down, or leaves it unchanged.

It also drives the highest frequency code the inner loop may use. That ceiling sits one resolution step above the target. When the chip has spare timing margin, the inner loop pushes against this ceiling. The outer loop reads that saturation as a sign of excess voltage and lowers the supply. When the reached frequency falls short of the target, margin is missing, and the supply goes up on the next evaluation.

Evaluations are paced by a slow sample tick through a programmable divider. A down-step needs the ceiling to be seen on a programmable number of consecutive evaluations. An up-step happens on the first short evaluation. The voltage code stays between a programmable floor and a programmable ceiling.

Top module: `freq_target_vloop`

## Requirements
- R1: While reset is active, `v_code` is loaded with parameter `V_START` (128 by default) and `f_ceiling` with 0. The `sample_tick` divider count and the run of consecutive spare evaluations are both set to zero.
- R2: One clock after `target_code` is presented, `f_ceiling` equals `target_code + 1`. When `target_code` is all ones, `f_ceiling` equals `target_code`.
- R3: An evaluation happens only on a clock where `sample_tick` is high. It happens on every (`eval_div`+1)-th such tick, counted from reset. On all other clocks `v_code` does not change.
- R4: On an evaluation where `meas_code < target_code`, `v_code` rises by exactly 1 at that clock edge, unless it is already at `v_ceil`.
- R5: On an evaluation where `meas_code == target_code`, `v_code` stays the same.
- R6: On an evaluation where `meas_code > target_code` (the inner loop has reached the ceiling), the evaluation counts as spare. `v_code` falls by exactly 1 only on the `dn_confirm`-th consecutive spare evaluation. A `dn_confirm` of 0 acts as 1. After a down-step, or after a spare evaluation that hits the floor, counting starts again from zero.
- R7: An up-step never takes `v_code` above `v_ceil`. At `v_ceil`, a short evaluation leaves it unchanged.
- R8: A down-step never takes `v_code` below `v_floor`. At `v_floor`, a confirmed spare evaluation leaves it unchanged.
- R9: An on-target or short evaluation clears the run of consecutive spare evaluations.
- R10: `v_code` changes by at most 1 per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | Slow pacing pulse, one clock wide |
| eval_div | input | DIV_W | One evaluation every eval_div+1 ticks |
| dn_confirm | input | STK_W | Consecutive spare evaluations needed before a down-step |
| target_code | input | F_W | Requested frequency code |
| meas_code | input | F_W | Frequency code the inner loop reached |
| v_floor | input | V_W | Lowest allowed voltage code |
| v_ceil | input | V_W | Highest allowed voltage code |
| v_code | output | V_W | Voltage command to the regulator |
| f_ceiling | output | F_W | Frequency limit for the inner loop |

## Verification
A corrupted spare-run count shows at the ports as a down-step that arrives one or more evaluations early or late. It becomes visible on the first spare evaluation that should, or should not, have confirmed. A divider count that is off shifts which `sample_tick` moves `v_code`, so the error appears within one divider period. A wrong verdict or saturation decision shows directly in `v_code` at the edge of that evaluation. The vector walk steps through a full climb to the ceiling, a descent with an interrupted spare run, and a stop at the floor, so each of these errors shows up within one vector.

// File: rtl/ftv_pkg.sv
// Shared types for the frequency-target voltage loop.
package ftv_pkg;
    // How the reached frequency compares with the requested frequency.
    typedef enum logic [1:0] {
        VERDICT_ON    = 2'd0,
        VERDICT_SHORT = 2'd1,
        VERDICT_SPARE = 2'd2
    } verdict_t;
endpackage

// File: rtl/ftv_tick_div.sv
// Tick divider: counts sample ticks and flags the tick on which an
// evaluation takes place (every eval_div+1 ticks).
// Assumes: eval_div is held steady between evaluations.
module ftv_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [DIV_W-1:0] eval_div,
    output logic             eval_now
);
    logic [DIV_W-1:0] tick_cnt;

    // Evaluation fires on the tick that completes the count.
    always_comb eval_now = sample_tick && (tick_cnt >= eval_div);

    // Advance the count on each tick and wrap it after an evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (sample_tick) begin
            if (eval_now) tick_cnt <= '0;
            else          tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ftv_margin_judge.sv
// Margin judge: classifies the reached frequency against the target and
// registers the frequency ceiling (target plus one step, saturating).
// Assumes: the inner loop never exceeds the ceiling this block drives.
module ftv_margin_judge
    import ftv_pkg::*;
#(
    parameter int F_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [F_W-1:0] target_code,
    input  logic [F_W-1:0] meas_code,
    output verdict_t       verdict,
    output logic [F_W-1:0] f_ceiling
);
    localparam logic [F_W-1:0] F_TOP = {F_W{1'b1}};

    logic [F_W-1:0] cap_next;

    // Ceiling sits one code above target, held at the top code.
    always_comb cap_next = (target_code == F_TOP) ? target_code : target_code + 1'b1;

    // Anything above the target can only be the ceiling: spare margin.
    always_comb begin
        if (meas_code < target_code)      verdict = VERDICT_SHORT;
        else if (meas_code > target_code) verdict = VERDICT_SPARE;
        else                              verdict = VERDICT_ON;
    end

    // Register the ceiling toward the inner loop.
    always_ff @(posedge clk) begin
        if (!rst_n) f_ceiling <= '0;
        else        f_ceiling <= cap_next;
    end
endmodule

// File: rtl/ftv_spare_streak.sv
// Spare streak: counts consecutive spare evaluations and grants a
// down-step when the run reaches dn_confirm (0 treated as 1).
// Assumes: verdict is valid whenever eval_now is high.
module ftv_spare_streak
    import ftv_pkg::*;
#(
    parameter int STK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_now,
    input  verdict_t         verdict,
    input  logic [STK_W-1:0] dn_confirm,
    output logic             lower_go
);
    logic [STK_W-1:0] run_cnt;
    logic [STK_W:0]   run_next;
    logic [STK_W:0]   need;

    // Length the run would reach with this evaluation, and length needed.
    always_comb begin
        run_next = {1'b0, run_cnt} + 1'b1;
        need     = (dn_confirm == '0) ? {{STK_W{1'b0}}, 1'b1} : {1'b0, dn_confirm};
    end

    // Grant a down-step when a spare evaluation completes the run.
    always_comb lower_go = eval_now && (verdict == VERDICT_SPARE) && (run_next >= need);

    // Grow the run on spare, restart it on grant or on any other verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (eval_now) begin
            if (verdict != VERDICT_SPARE || lower_go) run_cnt <= '0;
            else                                      run_cnt <= run_next[STK_W-1:0];
        end
    end
endmodule

// File: rtl/ftv_volt_step.sv
// Voltage stepper: holds the voltage code and moves it one code per
// evaluation, saturating at the programmed floor and ceiling.
// Assumes: v_floor <= v_ceil.
module ftv_volt_step
    import ftv_pkg::*;
#(
    parameter int V_W     = 8,
    parameter int V_START = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           eval_now,
    input  verdict_t       verdict,
    input  logic           lower_go,
    input  logic [V_W-1:0] v_floor,
    input  logic [V_W-1:0] v_ceil,
    output logic [V_W-1:0] v_code
);
    localparam logic [V_W-1:0] V_RST = V_W'(V_START);

    logic [V_W-1:0] v_next;

    // Choose the next code: raise on short, lower on a granted spare.
    always_comb begin
        v_next = v_code;
        if (verdict == VERDICT_SHORT) begin
            if (v_code < v_ceil) v_next = v_code + 1'b1;
        end else if (lower_go) begin
            if (v_code > v_floor) v_next = v_code - 1'b1;
        end
    end

    // Commit the new code only at evaluations.
    always_ff @(posedge clk) begin
        if (!rst_n)        v_code <= V_RST;
        else if (eval_now) v_code <= v_next;
    end
endmodule

// File: rtl/freq_target_vloop.sv
// Frequency-target voltage loop top: paces evaluations, judges the reached
// frequency against the target, confirms spare margin and steps the
// supply voltage code. Assumes meas_code comes from an inner loop bounded
// by f_ceiling, and that all inputs are synchronous to clk.
module freq_target_vloop
    import ftv_pkg::*;
#(
    parameter int F_W     = 8,
    parameter int V_W     = 8,
    parameter int DIV_W   = 8,
    parameter int STK_W   = 4,
    parameter int V_START = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [DIV_W-1:0] eval_div,
    input  logic [STK_W-1:0] dn_confirm,
    input  logic [F_W-1:0]   target_code,
    input  logic [F_W-1:0]   meas_code,
    input  logic [V_W-1:0]   v_floor,
    input  logic [V_W-1:0]   v_ceil,
    output logic [V_W-1:0]   v_code,
    output logic [F_W-1:0]   f_ceiling
);
    logic     eval_now;
    logic     lower_go;
    verdict_t verdict;

    ftv_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .eval_div(eval_div), .eval_now(eval_now)
    );

    ftv_margin_judge #(.F_W(F_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .target_code(target_code),
        .meas_code(meas_code), .verdict(verdict), .f_ceiling(f_ceiling)
    );

    ftv_spare_streak #(.STK_W(STK_W)) u_streak (
        .clk(clk), .rst_n(rst_n), .eval_now(eval_now), .verdict(verdict),
        .dn_confirm(dn_confirm), .lower_go(lower_go)
    );

    ftv_volt_step #(.V_W(V_W), .V_START(V_START)) u_vstep (
        .clk(clk), .rst_n(rst_n), .eval_now(eval_now), .verdict(verdict),
        .lower_go(lower_go), .v_floor(v_floor), .v_ceil(v_ceil), .v_code(v_code)
    );
endmodule

// File: rtl/ftv_checker.sv
// Port-level checker for freq_target_vloop, attached by bind.
module ftv_checker #(
    parameter int F_W = 8,
    parameter int V_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sample_tick,
    input logic [F_W-1:0] target_code,
    input logic [F_W-1:0] meas_code,
    input logic [V_W-1:0] v_floor,
    input logic [V_W-1:0] v_ceil,
    input logic [V_W-1:0] v_code,
    input logic [F_W-1:0] f_ceiling
);
    assert_quiet_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(v_code));

    assert_rise_only_when_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_code > $past(v_code)) |-> $past(meas_code < target_code));

    assert_fall_only_when_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_code < $past(v_code)) |-> $past(meas_code > target_code));

    assert_rise_within_ceil_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_code > $past(v_code)) |-> (v_code <= $past(v_ceil)));

    assert_fall_within_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_code < $past(v_code)) |-> (v_code >= $past(v_floor)));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_code == $past(v_code)) ||
        (v_code == V_W'($past(v_code) + 1'b1)) ||
        (v_code == V_W'($past(v_code) - 1'b1)));

    assert_ceiling_near_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((f_ceiling >= $past(target_code)) &&
                          (F_W'(f_ceiling - $past(target_code)) <= F_W'(1))));
endmodule

bind freq_target_vloop ftv_checker #(.F_W(F_W), .V_W(V_W)) u_ftv_checker (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .target_code(target_code), .meas_code(meas_code),
    .v_floor(v_floor), .v_ceil(v_ceil), .v_code(v_code), .f_ceiling(f_ceiling)
);

// File: tb/freq_target_vloop_bench.sv
`timescale 1ns/1ps
module freq_target_vloop_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic [7:0] eval_div = 8'd0;
    logic [3:0] dn_confirm = 4'd2;
    logic [7:0] target_code = 8'd50;
    logic [7:0] meas_code = 8'd50;
    logic [7:0] v_floor = 8'd126;
    logic [7:0] v_ceil = 8'd131;
    logic [7:0] v_code;
    logic [7:0] f_ceiling;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    freq_target_vloop u_freq_target_vloop (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .eval_div(eval_div),
        .dn_confirm(dn_confirm), .target_code(target_code), .meas_code(meas_code),
        .v_floor(v_floor), .v_ceil(v_ceil), .v_code(v_code), .f_ceiling(f_ceiling)
    );

    // Vectors {target, measured, expected v_code after the evaluation};
    // eval_div=0, dn_confirm=2, floor 126, ceiling 131, start at 128.
    localparam logic [23:0] VEC [20] = '{
        {8'd50, 8'd49, 8'd129}, {8'd50, 8'd49, 8'd130}, {8'd50, 8'd49, 8'd131},
        {8'd50, 8'd49, 8'd131}, {8'd50, 8'd50, 8'd131}, {8'd50, 8'd51, 8'd131},
        {8'd50, 8'd51, 8'd130}, {8'd50, 8'd51, 8'd130}, {8'd50, 8'd50, 8'd130},
        {8'd50, 8'd51, 8'd130}, {8'd50, 8'd51, 8'd129}, {8'd50, 8'd51, 8'd129},
        {8'd50, 8'd51, 8'd128}, {8'd50, 8'd51, 8'd128}, {8'd50, 8'd51, 8'd127},
        {8'd50, 8'd51, 8'd127}, {8'd50, 8'd51, 8'd126}, {8'd50, 8'd51, 8'd126},
        {8'd50, 8'd51, 8'd126}, {8'd50, 8'd49, 8'd127}
    };

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick(input logic [7:0] tgt, input logic [7:0] meas);
        @(negedge clk);
        target_code = tgt;
        meas_code   = meas;
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 v_code in reset", v_code, 128);
        check("R1 f_ceiling in reset", f_ceiling, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 ceiling is target+1", f_ceiling, 51);

        // Vector walk: climb, ceiling stop, confirmed descents, floor stop.
        for (int i = 0; i < 20; i++) begin
            tick(VEC[i][23:16], VEC[i][15:8]);
            check($sformatf("R4/R5/R6/R7/R8/R9 vector %0d", i), v_code, VEC[i][7:0]);
        end

        // R2: ceiling holds at the top code.
        @(negedge clk);
        target_code = 8'hFF;
        @(negedge clk);
        check("R2 ceiling saturates", f_ceiling, 255);
        target_code = 8'd7;
        @(negedge clk);
        check("R2 ceiling follows target", f_ceiling, 8);

        // R3: with eval_div=2 only the third tick evaluates.
        do_reset();
        eval_div = 8'd2;
        v_floor  = 8'd0;
        v_ceil   = 8'd255;
        tick(8'd50, 8'd40);
        check("R3 first tick ignored", v_code, 128);
        tick(8'd50, 8'd40);
        check("R3 second tick ignored", v_code, 128);
        meas_code = 8'd40;
        repeat (5) @(negedge clk);
        check("R3 no change without tick", v_code, 128);
        tick(8'd50, 8'd40);
        check("R3 third tick evaluates", v_code, 129);

        // R6: dn_confirm of 0 behaves as 1.
        do_reset();
        eval_div   = 8'd0;
        dn_confirm = 4'd0;
        tick(8'd50, 8'd51);
        check("R6 confirm zero acts as one", v_code, 127);
        tick(8'd50, 8'd51);
        check("R6 each spare lowers with one", v_code, 126);

        // R9: short evaluation mid-run clears the spare run (dn_confirm=3).
        do_reset();
        dn_confirm = 4'd3;
        tick(8'd50, 8'd51);
        tick(8'd50, 8'd51);
        tick(8'd50, 8'd49);
        check("R9 short raises", v_code, 129);
        tick(8'd50, 8'd51);
        tick(8'd50, 8'd51);
        check("R9 run restarted", v_code, 129);
        tick(8'd50, 8'd51);
        check("R6 third spare lowers", v_code, 128);

        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule